// File: doc/BRIEF.md
# Random-Search CNF Satisfiability Engine

This block hunts for a satisfying assignment of one conjunctive-normal-form Boolean formula that is fixed when the design is elaborated. Each clause is described by two masks over the variables. The positive mask lists the variables that appear plain in the clause. The negative mask lists the variables that appear complemented. A Fibonacci LFSR proposes one pseudo-random assignment per enabled clock. The proposal is captured into a result register. A combinational clause network judges the captured value and drives the satisfied flag.

While the flag is low, the result register keeps loading fresh candidates. When the flag rises, loading stops. The register then turns into a shift register and streams the winning assignment out on a single wire, most significant variable first. If no candidate satisfies the formula within a parameterised number of loads, the engine raises a sticky timeout and stops searching. Because the flag is judged on the registered candidate, the word streamed out is exactly the assignment that raised the flag.

Variable x(i+1) sits at bit i of the candidate. Clause k occupies bits [k*NVARS +: NVARS] of both mask parameters.

Top module: `sat_search_engine`

## Requirements
- R1: Reset is asynchronous and active low. During reset and right after it, the candidate register holds all zeros, `ser_out` is 0 and `timed_out` is 0. `sat_flag` shows the formula judged on the all-zeros assignment.
- R2: The LFSR is seeded with the nonzero LFSR_SEED. It steps only on a load cycle. Its next value is its current value shifted one place toward the MSB, with the XOR of the bits selected by LFSR_TAPS entering at bit 0. It never holds zero.
- R3: While searching, `sat_flag` is 1 exactly when every clause has a true literal under the candidate register. A literal is true when it is a positive-mask bit whose variable is 1, or a negative-mask bit whose variable is 0.
- R4: While searching with `search_en` = 1 and `sat_flag` = 0, and with fewer than TIMEOUT_LIMIT loads made, the candidate register takes the current LFSR value on each clock.
- R5: On an enabled clock while searching with `sat_flag` = 1, loading stops and shifting begins. For the next NVARS enabled clocks, `ser_out` presents the captured candidate one bit per enabled clock, starting at bit NVARS-1. `sat_flag` stays 1 throughout.
- R6: After the last bit has been sent, the engine rests in a finished state. In that state `ser_out` is 0 and `sat_flag` is 1 until reset.
- R7: With `search_en` = 0, no state changes, so all three outputs hold their values.
- R8: An enabled search clock with `sat_flag` = 0, after TIMEOUT_LIMIT loads, enters timeout. From then until reset, `timed_out` = 1, `sat_flag` = 0 and `ser_out` = 0.
- R9: The word collected from `ser_out` satisfies the formula.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| search_en | input | 1 | Advances search and shifting when 1; freezes the engine when 0 |
| sat_flag | output | 1 | Formula satisfied by the held candidate |
| ser_out | output | 1 | Serial solution, most significant variable first |
| timed_out | output | 1 | Search limit exhausted; sticky until reset |

## Verification
The bench aims at the hand-over from search to shifting. A design that loaded one more candidate after the flag rose would stream a word that fails the formula. A design that judged the LFSR output rather than the captured value would do the same. Enable gaps are placed both inside the search and inside the serial burst; a design that kept shifting while disabled would drop or repeat bits. An unsatisfiable formula must end in a timeout that never lets go. A shift counter that is off by one shows up as an extra or a missing serial bit before the finished state.

// File: rtl/sat_pkg.sv
package sat_pkg;

  typedef enum logic [1:0] {
    ST_SEARCH  = 2'd0,
    ST_SHIFT   = 2'd1,
    ST_DONE    = 2'd2,
    ST_TIMEOUT = 2'd3
  } srch_state_e;

endpackage

// File: rtl/sat_lfsr.sv
module sat_lfsr #(
  parameter int          W    = 4,
  parameter logic [W-1:0] TAPS = 4'b1100,
  parameter logic [W-1:0] SEED = 4'b0001
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv_i,
  output logic [W-1:0] state_o
);

  function automatic logic [W-1:0] lfsr_step(input logic [W-1:0] s);
    return {s[W-2:0], ^(s & TAPS)};
  endfunction

  logic [W-1:0] state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     state_q <= SEED;
    else if (adv_i) state_q <= lfsr_step(state_q);
  end

  assign state_o = state_q;

  // R2
  lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != '0);

  // R2
  lfsr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !adv_i |=> state_q == $past(state_q));

endmodule

// File: rtl/sat_clause_eval.sv
module sat_clause_eval #(
  parameter int                  NV  = 4,
  parameter int                  NCL = 3,
  parameter logic [NCL*NV-1:0]   POS = 12'h285,
  parameter logic [NCL*NV-1:0]   NEG = 12'h408
) (
  input  logic [NV-1:0]  asg_i,
  output logic [NCL-1:0] clause_ok_o,
  output logic           sat_o
);

  for (genvar k = 0; k < NCL; k++) begin : g_clause
    localparam logic [NV-1:0] PM = POS[k*NV +: NV];
    localparam logic [NV-1:0] NM = NEG[k*NV +: NV];
    assign clause_ok_o[k] = |((asg_i & PM) | (~asg_i & NM));
  end

  assign sat_o = &clause_ok_o;

endmodule

// File: rtl/sat_result_sreg.sv
module sat_result_sreg #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic         shift_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o,
  output logic         ser_o
);

  logic [W-1:0] q_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       q_q <= '0;
    else if (load_i)  q_q <= d_i;
    else if (shift_i) q_q <= {q_q[W-2:0], 1'b0};
  end

  assign q_o   = q_q;
  assign ser_o = q_q[W-1];

  // R4
  sreg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> q_q == $past(d_i));

  // R5
  sreg_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_i && !load_i) |=> q_q[W-1:1] == $past(q_q[W-2:0]));

endmodule

// File: rtl/sat_search_engine.sv
module sat_search_engine #(
  parameter int                        NVARS         = 4,
  parameter int                        NCLAUSES      = 3,
  parameter logic [NCLAUSES*NVARS-1:0] POS_LITS      = 12'h285,
  parameter logic [NCLAUSES*NVARS-1:0] NEG_LITS      = 12'h408,
  parameter logic [NVARS-1:0]          LFSR_TAPS     = 4'b1100,
  parameter logic [NVARS-1:0]          LFSR_SEED     = 4'b0001,
  parameter int                        TIMEOUT_LIMIT = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic search_en,
  output logic sat_flag,
  output logic ser_out,
  output logic timed_out
);
  import sat_pkg::*;

  localparam int CW = $clog2(TIMEOUT_LIMIT + 1);
  localparam int BW = $clog2(NVARS);
  localparam logic [CW-1:0] LIM_C  = CW'(TIMEOUT_LIMIT);
  localparam logic [BW-1:0] LAST_C = BW'(NVARS - 1);

  srch_state_e       state_q, state_d;
  logic [CW-1:0]     cnt_q;
  logic [BW-1:0]     bit_q;
  logic [NVARS-1:0]  lfsr_w, cand_w;
  logic [NCLAUSES-1:0] clause_ok_w;
  logic              eval_sat_w, ser_w;

  // named internal events
  logic searching_w, load_w, expire_w, found_w, shift_w, last_w;

  assign searching_w = (state_q == ST_SEARCH);
  assign load_w   = search_en && searching_w && !eval_sat_w && (cnt_q != LIM_C);
  assign expire_w = search_en && searching_w && !eval_sat_w && (cnt_q == LIM_C);
  assign found_w  = search_en && searching_w && eval_sat_w;
  assign shift_w  = search_en && (state_q == ST_SHIFT);
  assign last_w   = shift_w && (bit_q == LAST_C);

  sat_lfsr #(.W(NVARS), .TAPS(LFSR_TAPS), .SEED(LFSR_SEED)) u_lfsr (
    .clk(clk), .rst_n(rst_n), .adv_i(load_w), .state_o(lfsr_w)
  );

  sat_result_sreg #(.W(NVARS)) u_sreg (
    .clk(clk), .rst_n(rst_n), .load_i(load_w), .shift_i(shift_w),
    .d_i(lfsr_w), .q_o(cand_w), .ser_o(ser_w)
  );

  sat_clause_eval #(.NV(NVARS), .NCL(NCLAUSES), .POS(POS_LITS), .NEG(NEG_LITS)) u_eval (
    .asg_i(cand_w), .clause_ok_o(clause_ok_w), .sat_o(eval_sat_w)
  );

  always_comb begin
    state_d = state_q;
    if (found_w)       state_d = ST_SHIFT;
    else if (expire_w) state_d = ST_TIMEOUT;
    else if (last_w)   state_d = ST_DONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_SEARCH;
      cnt_q   <= '0;
      bit_q   <= '0;
    end else begin
      state_q <= state_d;
      if (load_w)       cnt_q <= cnt_q + 1'b1;
      if (found_w)      bit_q <= '0;
      else if (shift_w) bit_q <= bit_q + 1'b1;
    end
  end

  assign sat_flag  = searching_w ? eval_sat_w
                                 : (state_q == ST_SHIFT || state_q == ST_DONE);
  assign ser_out   = (state_q == ST_SHIFT) && ser_w;
  assign timed_out = (state_q == ST_TIMEOUT);

  // R4
  cand_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_w |=> cand_w == $past(lfsr_w));

  // R5
  flag_in_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    found_w |=> sat_flag);

  // R6
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_w |=> (!ser_out && sat_flag));

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !search_en |=> ($stable(sat_flag) && $stable(ser_out) && $stable(timed_out)));

  // R8
  timeout_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timed_out |=> (timed_out && !sat_flag && !ser_out));

  // R8
  timeout_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire_w |=> timed_out);

endmodule

// File: tb/sim_sat_search_engine.sv
module sim_ref_model #(
  parameter int                ID     = 0,
  parameter int                NV     = 4,
  parameter int                NCL    = 3,
  parameter logic [NCL*NV-1:0] POS    = 12'h285,
  parameter logic [NCL*NV-1:0] NEG    = 12'h408,
  parameter logic [NV-1:0]     TAPS   = 4'b1100,
  parameter logic [NV-1:0]     SEED   = 4'b0001,
  parameter int                LIMIT  = 100,
  parameter bit                EXPECT_SAT = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic dut_f,
  input  logic dut_s,
  input  logic dut_t,
  output int   checks,
  output int   fails,
  output logic finished
);

  logic [NV-1:0] lf, cand, word;
  int st, cnt, bitn, ncol;
  bit judged;

  function automatic bit meets(input logic [NV-1:0] a);
    for (int c = 0; c < NCL; c++) begin
      int lits = 0;
      for (int v = 0; v < NV; v++) begin
        if (POS[c*NV+v] == 1'b1 && a[v] == 1'b1) lits++;
        if (NEG[c*NV+v] == 1'b1 && a[v] == 1'b0) lits++;
      end
      if (lits == 0) return 1'b0;
    end
    return 1'b1;
  endfunction

  function automatic logic [NV-1:0] next_lf(input logic [NV-1:0] s);
    int ones = 0;
    for (int i = 0; i < NV; i++) if (TAPS[i] && s[i]) ones++;
    return (s << 1) | NV'(ones % 2);
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL inst%0d %s: actual %b expected %b at %0t", ID, req, act, exp, $time);
    end
  endtask

  initial begin
    checks = 0; fails = 0; judged = 0; ncol = 0; word = '0;
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lf = SEED; cand = '0; st = 0; cnt = 0; bitn = 0;
    end else if (en) begin
      case (st)
        0: if (meets(cand)) begin st = 1; bitn = 0; end
           else if (cnt == LIMIT) st = 3;
           else begin cand = lf; lf = next_lf(lf); cnt++; end
        1: begin
             cand = cand << 1;
             if (bitn == NV - 1) st = 2;
             bitn++;
           end
        default: ;
      endcase
    end
  end

  always @(negedge clk) begin
    if (!rst_n) begin
      chk("R1 reset ser_out", dut_s, 1'b0);
      chk("R1 reset timed_out", dut_t, 1'b0);
      chk("R1 reset sat_flag", dut_f, meets('0));
    end else begin
      chk("R2 R3 R4 R5 R6 R7 R8 sat_flag", dut_f, (st == 0) ? meets(cand) : (st == 1 || st == 2));
      chk("R2 R5 R6 R7 ser_out", dut_s, (st == 1) ? cand[NV-1] : 1'b0);
      chk("R8 R7 timed_out", dut_t, st == 3);
      if (st == 1 && en) begin
        word = {word[NV-2:0], dut_s};
        ncol++;
      end
      if (st == 2 && !judged) begin
        judged = 1;
        chk("R9 collected word satisfies formula", meets(word), 1'b1);
        chk("R5 serial bit count", ncol == NV, 1'b1);
      end
    end
  end

  assign finished = EXPECT_SAT ? (st == 2) : (st == 3);

endmodule

module sim_sat_search_engine;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  always #2 clk = ~clk;

  logic f0, s0, t0, f1, s1, t1, f2, s2, t2;
  int c0, e0, c1, e1, c2, e2;
  logic fin0, fin1, fin2;
  int top_checks = 0, top_fails = 0;
  bit reported = 0;

  sat_search_engine #(
    .NVARS(4), .NCLAUSES(3), .POS_LITS(12'h285), .NEG_LITS(12'h408),
    .LFSR_TAPS(4'b1100), .LFSR_SEED(4'b0001), .TIMEOUT_LIMIT(100)
  ) u0 (.clk(clk), .rst_n(rst_n), .search_en(en), .sat_flag(f0), .ser_out(s0), .timed_out(t0));

  sat_search_engine #(
    .NVARS(4), .NCLAUSES(2), .POS_LITS(8'h01), .NEG_LITS(8'h10),
    .LFSR_TAPS(4'b1100), .LFSR_SEED(4'b0001), .TIMEOUT_LIMIT(20)
  ) u1 (.clk(clk), .rst_n(rst_n), .search_en(en), .sat_flag(f1), .ser_out(s1), .timed_out(t1));

  sat_search_engine #(
    .NVARS(8), .NCLAUSES(4), .POS_LITS(32'h08508003), .NEG_LITS(32'h00200400),
    .LFSR_TAPS(8'b10111000), .LFSR_SEED(8'h5A), .TIMEOUT_LIMIT(300)
  ) u2 (.clk(clk), .rst_n(rst_n), .search_en(en), .sat_flag(f2), .ser_out(s2), .timed_out(t2));

  sim_ref_model #(.ID(0), .NV(4), .NCL(3), .POS(12'h285), .NEG(12'h408),
    .TAPS(4'b1100), .SEED(4'b0001), .LIMIT(100), .EXPECT_SAT(1'b1))
    m0 (.clk(clk), .rst_n(rst_n), .en(en), .dut_f(f0), .dut_s(s0), .dut_t(t0),
        .checks(c0), .fails(e0), .finished(fin0));

  sim_ref_model #(.ID(1), .NV(4), .NCL(2), .POS(8'h01), .NEG(8'h10),
    .TAPS(4'b1100), .SEED(4'b0001), .LIMIT(20), .EXPECT_SAT(1'b0))
    m1 (.clk(clk), .rst_n(rst_n), .en(en), .dut_f(f1), .dut_s(s1), .dut_t(t1),
        .checks(c1), .fails(e1), .finished(fin1));

  sim_ref_model #(.ID(2), .NV(8), .NCL(4), .POS(32'h08508003), .NEG(32'h00200400),
    .TAPS(8'b10111000), .SEED(8'h5A), .LIMIT(300), .EXPECT_SAT(1'b1))
    m2 (.clk(clk), .rst_n(rst_n), .en(en), .dut_f(f2), .dut_s(s2), .dut_t(t2),
        .checks(c2), .fails(e2), .finished(fin2));

  task automatic top_chk(input string req, input logic act, input logic exp);
    top_checks++;
    if (act !== exp) begin
      top_fails++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("End of test - %0d assertions evaluated, %0d failures",
               top_checks + c0 + c1 + c2, top_fails + e0 + e1 + e2);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    for (int cyc = 0; cyc < 2000; cyc++) begin
      @(posedge clk);
      // R7: enable gaps inside the search and inside each serial burst
      #1 en = !((cyc % 7) == 3 || (cyc >= 40 && cyc < 52) || (cyc % 11) == 6);
    end
    @(negedge clk);
    top_chk("R6 u0 rests with flag high", f0, 1'b1);
    top_chk("R6 u0 serial idle", s0, 1'b0);
    top_chk("R6 u0 model reached finished state", fin0, 1'b1);
    top_chk("R8 u1 timed out", t1, 1'b1);
    top_chk("R8 u1 flag low", f1, 1'b0);
    top_chk("R8 u1 model reached timeout", fin1, 1'b1);
    top_chk("R6 u2 rests with flag high", f2, 1'b1);
    top_chk("R6 u2 model reached finished state", fin2, 1'b1);
    report();
  end

  initial begin
    repeat (100000) @(posedge clk);
    top_checks++;
    top_fails++;
    $display("FAIL watchdog: actual hung expected finished");
    report();
  end

endmodule